// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host port and an asynchronous 16-bit static RAM. Each host request is a single word, either a read or a write, and carries a two-bit byte mask. The controller turns the request into a bus cycle on the RAM pins: address, active-low chip select, output enable, write strobe, one active-low enable per byte lane, and a shared bidirectional data bus.

Every phase of a bus cycle lasts a whole number of clock cycles. Each count comes from a nanosecond limit, which is a parameter, divided by the clock period parameter. The result is rounded up and is never less than one. A write asserts chip select, the address and the lane enables first. It then pulses the write strobe with output enable held high. The strobe rising ends the write, and the controller keeps driving the data bus for one further cycle. A read holds output enable low for the access count and captures the bus at the end of that window. The host sees one valid pulse per read. Ready returns only after the cycle-time count of the access has expired.

Top module: `sram_ctrl`

## Requirements
- R1: `ready_o` is high only while the bus is idle, and chip select is high whenever `ready_o` is high. A request is taken on a clock edge where `req_i` and `ready_o` are both high. After that edge, `ready_o` stays low for WCc cycles after a write and RCc cycles after a read. Here WCc = max(cyc(T_WC_NS), ASc+PWc+1) and RCc = max(cyc(T_RC_NS), AAc). Request inputs presented while `ready_o` is low have no effect.
- R2: Every count cyc(t) is ceil(t / CLK_PERIOD_NS), with a minimum of 1. ASc = cyc(T_AS_NS), AAc = cyc(T_AA_NS), and PWc = max(cyc(T_PWE_NS), cyc(T_SD_NS), cyc(T_AW_NS) - ASc, 1).
- R3: In a write, chip select, address and lane enables are active for ASc cycles before the write strobe falls. The strobe then stays low for PWc cycles. Output enable stays high for the whole write, and the address is stable for as long as chip select is low.
- R4: The controller drives the data bus with the write word while the strobe is low, and for one further cycle in which the strobe is high, chip select is still low and the address is unchanged. The bus is released at all other times, including whenever output enable is low.
- R5: `be_i[1]` selects the upper lane (data bits 15:8) and drives `sram_ub_no` low. `be_i[0]` selects the lower lane (bits 7:0) and drives `sram_lb_no` low. A write with mask 2'b00 leaves memory unchanged.
- R6: In a read, the write strobe stays high while chip select and output enable are low for AAc cycles. `rvalid_o` is a one-cycle pulse AAc cycles after the accepting edge. `rdata_o` then holds the captured bus, with lanes not selected by the mask reading as zero.
- R7: While `rst_ni` is low, chip select, output enable and write strobe are high, the data bus is released, `rvalid_o` is low and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write word |
| be_i | input | 2 | Byte mask, bit 1 upper lane, bit 0 lower lane |
| ready_o | output | 1 | Controller can take a request |
| rvalid_o | output | 1 | One-cycle read data valid |
| rdata_o | output | 16 | Read word, unselected lanes zero |
| sram_addr_o | output | ADDR_W | RAM address |
| sram_ce_no | output | 1 | RAM chip select, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write strobe, active low |
| sram_ub_no | output | 1 | Upper lane enable, active low |
| sram_lb_no | output | 1 | Lower lane enable, active low |
| sram_dq_io | inout | 16 | RAM data bus |

## Verification
Taking a request registers the phase on the same edge, so chip select and the lane enables change at that edge. The bench samples every output on the following falling edge. Its model counts down the cycle time from the accepting edge and predicts `ready_o` low for exactly WCc or RCc edges. It predicts `rvalid_o` on the edge AAc after acceptance, with the expected word taken from a shadow memory that applies each mask. A separate monitor time-stamps the bus pins and measures pulse width, data setup, address-to-strobe-end and access time in nanoseconds at each strobe and valid edge. The hold cycle and the released bus are checked at the falling edge after the strobe rises and in every cycle with chip select high.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_W_SETUP,
    PH_W_PULSE,
    PH_W_HOLD,
    PH_W_PAD,
    PH_R_ACCESS,
    PH_R_PAD
  } phase_e;

  // ceil(ns / period), never below one cycle
  function automatic int ns_to_cycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
`timescale 1ns/1ps
module sram_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_phase_seq.sv
`timescale 1ns/1ps
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int AS_CYC = 1,
  parameter int PW_CYC = 1,
  parameter int AA_CYC = 1,
  parameter int W_PAD  = 0,
  parameter int R_PAD  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_we_i,
  input  logic             zero_i,
  output phase_e           phase_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             capture_o
);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d    = phase_q;
    load_o     = 1'b0;
    load_val_o = '0;
    capture_o  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          if (start_we_i) begin
            phase_d    = PH_W_SETUP;
            load_val_o = CNT_W'(AS_CYC - 1);
          end else begin
            phase_d    = PH_R_ACCESS;
            load_val_o = CNT_W'(AA_CYC - 1);
          end
        end
      end
      PH_W_SETUP: begin
        if (zero_i) begin
          phase_d    = PH_W_PULSE;
          load_o     = 1'b1;
          load_val_o = CNT_W'(PW_CYC - 1);
        end
      end
      PH_W_PULSE: begin
        if (zero_i) begin
          phase_d = PH_W_HOLD;
          load_o  = 1'b1;
        end
      end
      PH_W_HOLD: begin
        if (zero_i) begin
          if (W_PAD > 0) begin
            phase_d    = PH_W_PAD;
            load_o     = 1'b1;
            load_val_o = CNT_W'(W_PAD - 1);
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_W_PAD: begin
        if (zero_i) phase_d = PH_IDLE;
      end
      PH_R_ACCESS: begin
        if (zero_i) begin
          capture_o = 1'b1;
          if (R_PAD > 0) begin
            phase_d    = PH_R_PAD;
            load_o     = 1'b1;
            load_val_o = CNT_W'(R_PAD - 1);
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_R_PAD: begin
        if (zero_i) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/sram_byte_lane.sv
`timescale 1ns/1ps
module sram_byte_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              capture_i,
  input  logic [LANE_W-1:0] bus_i,
  output logic [LANE_W-1:0] wbyte_o,
  output logic              en_o,
  output logic [LANE_W-1:0] rbyte_o
);

  logic [LANE_W-1:0] wbyte_q, rbyte_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbyte_q <= '0;
      en_q    <= 1'b0;
    end else if (latch_i) begin
      wbyte_q <= wdata_i;
      en_q    <= en_i;
    end
  end

  // unselected lane floats on the bus; return zero instead
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rbyte_q <= '0;
    else if (capture_i) rbyte_q <= en_q ? bus_i : '0;
  end

  assign wbyte_o = wbyte_q;
  assign en_o    = en_q;
  assign rbyte_o = rbyte_q;

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_AS_NS       = 0,
  parameter int T_PWE_NS      = 9,
  parameter int T_SD_NS       = 6,
  parameter int T_AW_NS       = 9,
  parameter int T_WC_NS       = 12,
  parameter int T_AA_NS       = 12,
  parameter int T_RC_NS       = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [15:0]       rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic              sram_ub_no,
  output logic              sram_lb_no,
  inout  wire  [15:0]       sram_dq_io
);

  localparam int DATA_W  = 16;
  localparam int LANE_W  = 8;
  localparam int LANES   = DATA_W / LANE_W;

  localparam int AS_CYC  = ns_to_cycles(T_AS_NS,  CLK_PERIOD_NS);
  localparam int PWE_CYC = ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS);
  localparam int SD_CYC  = ns_to_cycles(T_SD_NS,  CLK_PERIOD_NS);
  localparam int AW_CYC  = ns_to_cycles(T_AW_NS,  CLK_PERIOD_NS);
  localparam int WC_CYC  = ns_to_cycles(T_WC_NS,  CLK_PERIOD_NS);
  localparam int AA_CYC  = ns_to_cycles(T_AA_NS,  CLK_PERIOD_NS);
  localparam int RC_CYC  = ns_to_cycles(T_RC_NS,  CLK_PERIOD_NS);
  // setup + pulse must also cover address/select to write end
  localparam int PW_CYC  = imax(imax(PWE_CYC, SD_CYC), imax(AW_CYC - AS_CYC, 1));
  localparam int W_USED  = AS_CYC + PW_CYC + 1;
  localparam int W_PAD   = imax(WC_CYC - W_USED, 0);
  localparam int R_PAD   = imax(RC_CYC - AA_CYC, 0);
  localparam int MAX_CNT = imax(imax(AS_CYC, PW_CYC), imax(AA_CYC, imax(W_PAD, R_PAD)));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  phase_e             phase;
  logic               accept, cnt_load, cnt_zero, capture;
  logic [CNT_W-1:0]   cnt_val;
  logic [ADDR_W-1:0]  addr_q;
  logic               rvalid_q;
  logic               bus_sel, dq_oe;
  logic [DATA_W-1:0]  dq_out, rdata;
  logic [LANES-1:0]   lane_en;

  assign ready_o = (phase == PH_IDLE);
  assign accept  = req_i & ready_o;

  sram_phase_cnt #(
    .CNT_W      (CNT_W)
  ) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  sram_phase_seq #(
    .CNT_W      (CNT_W),
    .AS_CYC     (AS_CYC),
    .PW_CYC     (PW_CYC),
    .AA_CYC     (AA_CYC),
    .W_PAD      (W_PAD),
    .R_PAD      (R_PAD)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .start_we_i (we_i),
    .zero_i     (cnt_zero),
    .phase_o    (phase),
    .load_o     (cnt_load),
    .load_val_o (cnt_val),
    .capture_o  (capture)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane #(
      .LANE_W    (LANE_W)
    ) i_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .latch_i   (accept),
      .wdata_i   (wdata_i[g*LANE_W +: LANE_W]),
      .en_i      (be_i[g]),
      .capture_i (capture),
      .bus_i     (sram_dq_io[g*LANE_W +: LANE_W]),
      .wbyte_o   (dq_out[g*LANE_W +: LANE_W]),
      .en_o      (lane_en[g]),
      .rbyte_o   (rdata[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept) addr_q <= addr_i;
      rvalid_q <= capture;
    end
  end

  assign bus_sel = (phase == PH_W_SETUP) || (phase == PH_W_PULSE) ||
                   (phase == PH_W_HOLD)  || (phase == PH_R_ACCESS);
  assign dq_oe   = (phase == PH_W_PULSE) || (phase == PH_W_HOLD);

  assign sram_addr_o = addr_q;
  assign sram_ce_no  = ~bus_sel;
  assign sram_we_no  = ~(phase == PH_W_PULSE);
  assign sram_oe_no  = ~(phase == PH_R_ACCESS);
  assign sram_ub_no  = ~(bus_sel & lane_en[1]);
  assign sram_lb_no  = ~(bus_sel & lane_en[0]);
  assign sram_dq_io  = dq_oe ? dq_out : {DATA_W{1'bz}};

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata;

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int PW_CYC = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic              rvalid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              dq_oe_i
);

  logic [15:0] we_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            we_lo_cnt <= '0;
    else if (!we_ni)        we_lo_cnt <= (we_lo_cnt == 16'hffff) ? we_lo_cnt : we_lo_cnt + 16'd1;
    else                    we_lo_cnt <= '0;
  end

  assert_idle_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> ce_ni);

  assert_strobe_in_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> (!ce_ni && oe_ni));

  assert_pulse_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_ni) |-> (int'(we_lo_cnt) >= PW_CYC));

  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && $past(!ce_ni)) |-> $stable(addr_i));

  assert_hold_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_ni) |-> (dq_oe_i && !ce_ni));

  assert_no_drive_on_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> !dq_oe_i);

  assert_rvalid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |=> !rvalid_i);

  assert_rvalid_after_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> $past(!oe_ni));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .PW_CYC   (PW_CYC)
) i_sram_ctrl_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_i  (ready_o),
  .rvalid_i (rvalid_o),
  .addr_i   (sram_addr_o),
  .ce_ni    (sram_ce_no),
  .oe_ni    (sram_oe_no),
  .we_ni    (sram_we_no),
  .dq_oe_i  (dq_oe)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;

  localparam int PER    = 20;
  localparam int ADDR_W = 8;
  localparam int AS_NS  = 0;
  localparam int PWE_NS = 30;
  localparam int SD_NS  = 6;
  localparam int AW_NS  = 9;
  localparam int WC_NS  = 110;
  localparam int AA_NS  = 45;
  localparam int RC_NS  = 70;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int AS_C  = cyc(AS_NS);
  localparam int PW_A  = (cyc(PWE_NS) > cyc(SD_NS)) ? cyc(PWE_NS) : cyc(SD_NS);
  localparam int PW_B  = (cyc(AW_NS) - AS_C > 1) ? cyc(AW_NS) - AS_C : 1;
  localparam int PW_C  = (PW_A > PW_B) ? PW_A : PW_B;
  localparam int WC_C  = (cyc(WC_NS) > AS_C + PW_C + 1) ? cyc(WC_NS) : AS_C + PW_C + 1;
  localparam int AA_C  = cyc(AA_NS);
  localparam int RC_C  = (cyc(RC_NS) > AA_C) ? cyc(RC_NS) : AA_C;

  logic              clk, rst_n;
  logic              req, we;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       wdata;
  logic [1:0]        be;
  logic              ready_o, rvalid_o;
  logic [15:0]       rdata_o;
  logic [ADDR_W-1:0] sram_addr;
  logic              ce_n, oe_n, we_n, ub_n, lb_n;
  wire  [15:0]       dq;

  int checks = 0;
  int fails  = 0;
  int cyc_cnt = 0;

  sram_ctrl #(
    .ADDR_W(ADDR_W), .CLK_PERIOD_NS(PER), .T_AS_NS(AS_NS), .T_PWE_NS(PWE_NS),
    .T_SD_NS(SD_NS), .T_AW_NS(AW_NS), .T_WC_NS(WC_NS), .T_AA_NS(AA_NS), .T_RC_NS(RC_NS)
  ) i_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready_o), .rvalid_o(rvalid_o),
    .rdata_o(rdata_o), .sram_addr_o(sram_addr), .sram_ce_no(ce_n),
    .sram_oe_no(oe_n), .sram_we_no(we_n), .sram_ub_no(ub_n), .sram_lb_no(lb_n),
    .sram_dq_io(dq)
  );

  // released bus reads as all ones
  for (genvar b = 0; b < 16; b++) begin : g_pu
    pullup (dq[b]);
  end

  initial clk = 1'b0;
  always #(PER/2) clk = ~clk;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural RAM
  logic [15:0] mem    [0:255];
  logic [15:0] shadow [0:255];
  wire rd_drv = !ce_n && !oe_n && we_n;
  assign dq[15:8] = (rd_drv && !ub_n) ? mem[sram_addr][15:8] : 8'hzz;
  assign dq[7:0]  = (rd_drv && !lb_n) ? mem[sram_addr][7:0]  : 8'hzz;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 16'h0307 + 16'h4000);
      shadow[i] = 16'(i * 16'h0307 + 16'h4000);
    end
  end

  always @(posedge we_n) begin
    if (rst_n && !ce_n) begin
      if (!ub_n) mem[sram_addr][15:8] = dq[15:8];
      if (!lb_n) mem[sram_addr][7:0]  = dq[7:0];
    end
  end

  // time-stamped protocol monitor
  realtime t_addr = 0, t_ce = 0, t_wef = 0, t_dq = 0;
  always @(sram_addr) t_addr = $realtime;
  always @(negedge ce_n) t_ce = $realtime;
  always @(dq) t_dq = $realtime;

  always @(negedge we_n) begin
    if (rst_n) begin
      t_wef = $realtime;
      chk(oe_n == 1'b1, "R3 oe high at strobe fall", 32'(oe_n), 32'd1);
      chk(($realtime - t_addr) >= AS_NS, "R3 address setup", 32'(int'($realtime - t_addr)), 32'(AS_NS));
    end
  end

  always @(posedge we_n) begin
    if (rst_n && !ce_n) begin
      chk(($realtime - t_wef) >= PWE_NS, "R3 strobe width", 32'(int'($realtime - t_wef)), 32'(PWE_NS));
      chk(($realtime - t_dq) >= SD_NS, "R3 data setup", 32'(int'($realtime - t_dq)), 32'(SD_NS));
      chk(($realtime - t_ce) >= AW_NS, "R3 select to end", 32'(int'($realtime - t_ce)), 32'(AW_NS));
      chk(($realtime - t_addr) >= AW_NS, "R3 address to end", 32'(int'($realtime - t_addr)), 32'(AW_NS));
    end
  end

  always @(posedge rvalid_o) begin
    if (rst_n)
      chk(($realtime - t_addr) >= AA_NS, "R6 access time", 32'(int'($realtime - t_addr)), 32'(AA_NS));
  end

  // reference model, updated on each rising edge from pre-edge values
  int          busy = 0, rvc = 0;
  logic        exp_ready = 1'b1, exp_rvalid = 1'b0;
  logic [15:0] exp_rdata = '0, pend = '0, cur_wdata = '0;
  logic [1:0]  cur_mask = '0;
  logic [7:0]  cur_addr = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy = 0; rvc = 0; exp_ready = 1'b1; exp_rvalid = 1'b0;
    end else begin
      exp_rvalid = 1'b0;
      if (rvc > 0) begin
        rvc--;
        if (rvc == 0) begin
          exp_rvalid = 1'b1;
          exp_rdata  = pend;
        end
      end
      if (busy > 0) busy--;
      if (req && ready_o) begin
        cur_mask  = be;
        cur_addr  = addr;
        cur_wdata = wdata;
        if (we) begin
          busy = WC_C;
          if (be[1]) shadow[addr][15:8] = wdata[15:8];
          if (be[0]) shadow[addr][7:0]  = wdata[7:0];
        end else begin
          busy = RC_C;
          rvc  = AA_C;
          pend = shadow[addr] & {{8{be[1]}}, {8{be[0]}}};
        end
      end
      exp_ready = (busy == 0);
    end
  end

  // compare every cycle on the falling edge
  logic prev_we_low = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ready_o == 1'b1, "R7 ready in reset", 32'(ready_o), 32'd1);
      chk({ce_n, oe_n, we_n} == 3'b111, "R7 strobes in reset", 32'({ce_n, oe_n, we_n}), 32'h7);
      chk(rvalid_o == 1'b0, "R7 rvalid in reset", 32'(rvalid_o), 32'd0);
      chk(dq == 16'hffff, "R7 bus released in reset", 32'(dq), 32'hffff);
      prev_we_low = 1'b0;
    end else begin
      chk(ready_o == exp_ready, "R1 R2 ready timing", 32'(ready_o), 32'(exp_ready));
      chk(rvalid_o == exp_rvalid, "R6 R2 rvalid timing", 32'(rvalid_o), 32'(exp_rvalid));
      if (exp_rvalid)
        chk(rdata_o == exp_rdata, "R5 R6 read data", 32'(rdata_o), 32'(exp_rdata));
      if (ce_n)
        chk(dq == 16'hffff, "R4 bus released when idle", 32'(dq), 32'hffff);
      else
        chk({ub_n, lb_n} == ~cur_mask, "R5 lane enables", 32'({ub_n, lb_n}), 32'(~cur_mask));
      if (!we_n)
        chk(dq == cur_wdata, "R4 data during strobe", 32'(dq), 32'(cur_wdata));
      if (we_n && prev_we_low)
        chk(!ce_n && dq == cur_wdata && sram_addr == cur_addr, "R4 hold cycle",
            32'({ce_n, dq}), 32'(cur_wdata));
      prev_we_low = !we_n;
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      fails++;
      $display("FAIL R1 watchdog act=0x%0h exp=0x0", cyc_cnt);
      report();
    end
  end

  task automatic op(input bit w, input logic [7:0] a, input logic [15:0] d, input logic [1:0] m);
    while (!ready_o) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = m;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; be = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R5 full, upper, lower, empty mask
    op(1'b1, 8'h10, 16'ha5c3, 2'b11);
    op(1'b0, 8'h10, 16'h0000, 2'b11);
    op(1'b1, 8'h10, 16'h77aa, 2'b10);
    op(1'b0, 8'h10, 16'h0000, 2'b11);
    op(1'b1, 8'h10, 16'h5519, 2'b01);
    op(1'b0, 8'h10, 16'h0000, 2'b11);
    op(1'b1, 8'h10, 16'h0000, 2'b00);
    op(1'b0, 8'h10, 16'h0000, 2'b11);
    op(1'b0, 8'h10, 16'h0000, 2'b01);
    op(1'b0, 8'h10, 16'h0000, 2'b10);
    // R1 requests while busy are ignored
    op(1'b1, 8'h30, 16'h1234, 2'b11);
    req = 1'b1; we = 1'b1; addr = 8'h31; wdata = 16'hdead; be = 2'b11;
    idle(2);
    req = 1'b0;
    op(1'b0, 8'h31, 16'h0000, 2'b11);
    op(1'b0, 8'h30, 16'h0000, 2'b11);
    op(1'b0, 8'h80, 16'h0000, 2'b11);
    // R3 R6 back-to-back traffic
    for (int i = 0; i < 16; i++) op(1'b1, 8'(8'h40 + i), 16'(16'h0203 + i * 16'h0101), 2'b11);
    for (int i = 0; i < 16; i++) op(1'b0, 8'(8'h40 + i), 16'h0000, 2'(i % 3 + 1));
    op(1'b1, 8'h50, 16'h0f0f, 2'b11);
    op(1'b0, 8'h50, 16'h0000, 2'b11);
    idle(10);
    report();
  end

endmodule